// File: doc/BRIEF.md
# Comma-Based Receive Word Aligner

A deserializer delivers 10-bit parallel words whose boundary has no fixed relation to the boundary the transmitter used. This block recovers that boundary. Each incoming word can first be complemented (polarity inversion) and have its bit order flipped. The block then keeps the current word and the word before it, forms a 19-bit search window, and compares all ten possible 10-bit slices of that window with a programmable alignment pattern at the same time. A barrel shifter selects one slice as the aligned output word.

Two run-time modes exist. In manual alignment mode, every detection of the pattern locks the shift offset to the position where it was found, so the aligned word carries the pattern in its least significant bits. In bit-slip mode, no automatic search takes place. Each rising edge of a slip request moves the offset by one bit. The pattern can be compared on its full 10 bits or on its low 7 bits only. It can also be matched in both running-disparity forms, true and complemented.

Top module: `rx_word_aligner`

## Requirements
- R1: While `rst` is high at a clock edge, `aligned_word`, `pat_hit` and `synced` become 0 and the shift offset becomes 0.
- R2: Bit 0 of `rx_word` is the earliest received bit. If words w(n-1) and w(n) are sampled at consecutive edges, the next edge loads `aligned_word` with bits [s+9:s] of the 20-bit value {w(n), w(n-1)}. Here w means the word after the optional inversion and reversal, and s is the offset selected in that cycle (0..9).
- R3: With `mode_sel`=0 (manual), if any offset matches the pattern, that cycle uses the matching offset and locks it for later cycles. The resulting `aligned_word` holds the pattern in its least significant bits, and `pat_hit` is 1 with it.
- R4: With `pat_short`=1, only bits [6:0] of `align_pat` are compared and bits [9:7] are don't-care. With `pat_short`=0, all 10 bits must match.
- R5: With `dual_disp`=1, a slice equal to the bitwise complement of the pattern (over the compared bits) also counts as a match. With `dual_disp`=0, the complement is ignored.
- R6: With `mode_sel`=1 (bit-slip), each 0-to-1 transition of `slip_req` advances the offset by one, wrapping from 9 to 0. Without a transition the offset stays unchanged, and detected patterns never move it.
- R7: `pat_hit` is 1 exactly for output words whose slice at the selected offset matched the pattern, in either mode.
- R8: `synced` is set by a manual-mode match. It is cleared in the cycle after `mode_sel` differs from its value at the previous edge, and it is never set in bit-slip mode.
- R9: With `pol_inv`=1, every incoming bit is complemented before the search.
- R10: With `bit_rev`=1, bit i of each incoming word is moved to bit 9-i before the search.
- R11: If several offsets match in the same cycle, the lowest offset is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_word | input | 10 | Parallel word from the deserializer, bit 0 received first |
| mode_sel | input | 1 | 0 = manual pattern alignment, 1 = bit-slip |
| align_pat | input | 10 | Alignment pattern |
| pat_short | input | 1 | 1 = compare low 7 pattern bits only |
| dual_disp | input | 1 | 1 = also match the complemented pattern |
| pol_inv | input | 1 | 1 = complement incoming bits |
| bit_rev | input | 1 | 1 = reverse bit order within each word |
| slip_req | input | 1 | Rising edge moves the offset by one bit in bit-slip mode |
| aligned_word | output | 10 | Realigned output word |
| pat_hit | output | 1 | Pattern present at the selected offset of this output word |
| synced | output | 1 | Alignment acquired in manual mode |

## Verification
The embedded properties run on every cycle. They check that the offset stays in range, that it holds between slip edges, and that it wraps from 9 to 0. They also check that `synced` drops after a mode change and stays low in bit-slip mode, and that every asserted `pat_hit` comes with an output word that matches the pattern over the compared bits. The bench scenarios are needed for the rest: selecting the lowest matching offset, the effects of the 7-bit mask, the complemented match, inversion and reversal, the end-to-end latency, and the return to the same word after ten slips.

// File: rtl/aln_pkg.sv
package aln_pkg;
    localparam int unsigned WORD_W  = 10;
    localparam int unsigned SHORT_W = 7;
    localparam int unsigned OFF_W   = $clog2(WORD_W);

    typedef enum logic {
        MODE_MANUAL = 1'b0,
        MODE_SLIP   = 1'b1
    } align_mode_e;

    typedef struct packed {
        logic             hit;
        logic [OFF_W-1:0] pos;
    } search_t;
endpackage

// File: rtl/aln_front.sv
module aln_front #(
    parameter int unsigned W = aln_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic         inv,
    input  logic         rev,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] pol;
    logic [W-1:0] fixed;

    always_comb begin
        pol = inv ? ~din : din;
        for (int i = 0; i < int'(W); i++) begin
            fixed[i] = rev ? pol[W-1-i] : pol[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            prev <= '0;
        end else begin
            cur  <= fixed;
            prev <= cur;
        end
    end
endmodule

// File: rtl/aln_search.sv
module aln_search
    import aln_pkg::*;
#(
    parameter int unsigned W = aln_pkg::WORD_W
) (
    input  logic [2*W-2:0] window,
    input  logic [W-1:0]   pat,
    input  logic [W-1:0]   mask,
    input  logic           dual,
    output logic [W-1:0]   hit_vec,
    output search_t        first
);
    for (genvar k = 0; k < int'(W); k++) begin : g_off
        logic [W-1:0] slice;
        assign slice      = window[k +: W];
        assign hit_vec[k] = (((slice ^ pat) & mask) == '0)
                         || (dual && (((slice ^ ~pat) & mask) == '0));
    end

    // lowest offset wins (R11)
    always_comb begin
        first = '0;
        for (int k = int'(W) - 1; k >= 0; k--) begin
            if (hit_vec[k]) begin
                first.hit = 1'b1;
                first.pos = OFF_W'(k);
            end
        end
    end
endmodule

// File: rtl/aln_ctrl.sv
module aln_ctrl
    import aln_pkg::*;
#(
    parameter int unsigned W = aln_pkg::WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_sel,
    input  logic             slip_req,
    input  search_t          first,
    output logic [OFF_W-1:0] sel,
    output logic             synced
);
    align_mode_e      mode, mode_q;
    logic             slip_q;
    logic             slip_edge;
    logic             lock_now;
    logic [OFF_W-1:0] off;

    assign mode      = align_mode_e'(mode_sel);
    assign slip_edge = (mode == MODE_SLIP) && slip_req && !slip_q;
    assign lock_now  = (mode == MODE_MANUAL) && first.hit;
    assign sel       = lock_now ? first.pos : off;

    always_ff @(posedge clk) begin
        if (rst) begin
            off    <= '0;
            synced <= 1'b0;
            mode_q <= MODE_MANUAL;
            slip_q <= 1'b0;
        end else begin
            mode_q <= mode;
            slip_q <= slip_req;
            if (lock_now) begin
                off <= first.pos;
            end else if (slip_edge) begin
                off <= (off == OFF_W'(W - 1)) ? '0 : off + 1'b1;
            end
            if (mode != mode_q) begin
                synced <= 1'b0;
            end else if (lock_now) begin
                synced <= 1'b1;
            end
        end
    end

    a_r6_offset_range: assert property (@(posedge clk) disable iff (rst)
        off < OFF_W'(W));

    a_r6_hold_between_slips: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SLIP && !(slip_req && !slip_q)) |=> $stable(off));

    a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SLIP && slip_req && !slip_q && off == OFF_W'(W - 1)) |=> (off == '0));

    a_r8_clear_on_mode_change: assert property (@(posedge clk) disable iff (rst)
        (mode != mode_q) |=> !synced);

    a_r8_never_in_slip: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SLIP) |-> !synced);
endmodule

// File: rtl/rx_word_aligner.sv
module rx_word_aligner
    import aln_pkg::*;
#(
    parameter int unsigned W       = aln_pkg::WORD_W,
    parameter int unsigned SHORT_W = aln_pkg::SHORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rx_word,
    input  logic         mode_sel,
    input  logic [W-1:0] align_pat,
    input  logic         pat_short,
    input  logic         dual_disp,
    input  logic         pol_inv,
    input  logic         bit_rev,
    input  logic         slip_req,
    output logic [W-1:0] aligned_word,
    output logic         pat_hit,
    output logic         synced
);
    localparam logic [W-1:0] SHORT_MASK = {{(W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

    logic [W-1:0]     cur, prev;
    logic [2*W-1:0]   window;
    logic [W-1:0]     mask;
    logic [W-1:0]     hit_vec;
    search_t          first;
    logic [OFF_W-1:0] sel;

    assign window = {cur, prev};
    assign mask   = pat_short ? SHORT_MASK : '1;

    aln_front #(.W(W)) i_front (
        .clk (clk),
        .rst (rst),
        .din (rx_word),
        .inv (pol_inv),
        .rev (bit_rev),
        .cur (cur),
        .prev(prev)
    );

    aln_search #(.W(W)) i_search (
        .window (window[2*W-2:0]),
        .pat    (align_pat),
        .mask   (mask),
        .dual   (dual_disp),
        .hit_vec(hit_vec),
        .first  (first)
    );

    aln_ctrl #(.W(W)) i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .mode_sel(mode_sel),
        .slip_req(slip_req),
        .first   (first),
        .sel     (sel),
        .synced  (synced)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            aligned_word <= '0;
            pat_hit      <= 1'b0;
        end else begin
            aligned_word <= window[sel +: W];
            pat_hit      <= hit_vec[sel];
        end
    end

    // R3 / R7: a flagged output word carries the pattern in its low bits
    a_r3_pattern_in_lsb: assert property (@(posedge clk) disable iff (rst)
        pat_hit |-> ((((aligned_word ^ $past(align_pat)) & $past(mask)) == '0)
                  || ($past(dual_disp)
                      && (((aligned_word ^ ~$past(align_pat)) & $past(mask)) == '0))));
endmodule

// File: tb/test_rx_word_aligner.sv
module test_rx_word_aligner;
    localparam logic [9:0] COMMA = 10'b0011111010;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] rx_word = '0;
    logic       mode_sel = 1'b0;
    logic [9:0] align_pat = COMMA;
    logic       pat_short = 1'b0;
    logic       dual_disp = 1'b0;
    logic       pol_inv = 1'b0;
    logic       bit_rev = 1'b0;
    logic       slip_req = 1'b0;
    logic [9:0] aligned_word;
    logic       pat_hit;
    logic       synced;

    always #2.5 clk = ~clk;

    rx_word_aligner i_rx_word_aligner (
        .clk(clk), .rst(rst), .rx_word(rx_word), .mode_sel(mode_sel),
        .align_pat(align_pat), .pat_short(pat_short), .dual_disp(dual_disp),
        .pol_inv(pol_inv), .bit_rev(bit_rev), .slip_req(slip_req),
        .aligned_word(aligned_word), .pat_hit(pat_hit), .synced(synced)
    );

    int    checks = 0;
    int    failures = 0;
    int    hits = 0;
    logic [9:0] hit_word = '0;
    string cur_tag = "R1";
    bit    started = 0;
    bit    fill_bit = 0;
    bit    bq[$];

    task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%0h expected=%0h at %0t", req, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    function automatic logic [9:0] m_pre(input logic [9:0] w, input logic inv, input logic rev);
        logic [9:0] t, r;
        t = inv ? ~w : w;
        for (int i = 0; i < 10; i++) r[i] = rev ? t[9-i] : t[i];
        return r;
    endfunction

    function automatic bit m_match(input logic [9:0] s, input logic [9:0] p, input logic sh, input logic du);
        int n = sh ? 7 : 10;
        bit same = 1, comp = du;
        for (int i = 0; i < n; i++) begin
            if (s[i] != p[i]) same = 0;
            if (s[i] == p[i]) comp = 0;
        end
        return same || comp;
    endfunction

    logic [9:0] m_cur = '0, m_prev = '0, m_dout = '0;
    logic       m_pd = 0, m_sync = 0, m_modeq = 0, m_bsq = 0;
    int         m_off = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_cur = '0; m_prev = '0; m_dout = '0; m_pd = 0; m_sync = 0;
            m_modeq = 0; m_bsq = 0; m_off = 0;
        end else begin
            logic [19:0] win;
            int lowest, s;
            win = {m_cur, m_prev};
            lowest = -1;
            for (int k = 9; k >= 0; k--)
                if (m_match(win[k +: 10], align_pat, pat_short, dual_disp)) lowest = k;
            s = (!mode_sel && lowest >= 0) ? lowest : m_off;
            m_dout = win[s +: 10];
            m_pd = m_match(m_dout, align_pat, pat_short, dual_disp);
            if (mode_sel != m_modeq) m_sync = 0;
            else if (!mode_sel && lowest >= 0) m_sync = 1;
            if (!mode_sel && lowest >= 0) m_off = lowest;
            else if (mode_sel && slip_req && !m_bsq) m_off = (m_off + 1) % 10;
            m_modeq = mode_sel;
            m_bsq = slip_req;
            m_prev = m_cur;
            m_cur = m_pre(rx_word, pol_inv, bit_rev);
        end
    end

    // driver and per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            check(aligned_word == m_dout, {cur_tag, " R2 word"}, aligned_word, m_dout);
            check(pat_hit == m_pd, {cur_tag, " R7 hit"}, pat_hit, m_pd);
            check(synced == m_sync, {cur_tag, " R8 sync"}, synced, m_sync);
            if (pat_hit) begin
                hits++;
                hit_word = aligned_word;
            end
        end
        for (int i = 0; i < 10; i++)
            rx_word[i] = (bq.size() > 0) ? bq.pop_front() : fill_bit;
    end

    task automatic at_neg();
        @(negedge clk);
        #1;
    endtask

    task automatic push_fill(input int n, input bit v);
        for (int i = 0; i < n; i++) bq.push_back(v);
    endtask

    task automatic push_word(input logic [9:0] w);
        for (int i = 0; i < 10; i++) bq.push_back(w[i]);
    endtask

    task automatic drain();
        while (bq.size() > 0) at_neg();
        repeat (4) at_neg();
    endtask

    function automatic logic [9:0] rev10(input logic [9:0] w);
        logic [9:0] r;
        for (int i = 0; i < 10; i++) r[i] = w[9-i];
        return r;
    endfunction

    initial begin
        repeat (3) at_neg();
        check(aligned_word == 0, "R1 reset word", aligned_word, 0);
        check(pat_hit == 0, "R1 reset hit", pat_hit, 0);
        check(synced == 0, "R1 reset sync", synced, 0);
        rst = 0;
        started = 1;
        repeat (4) at_neg();

        // manual lock on a comma at bit phase 3
        cur_tag = "R3";
        hits = 0;
        push_fill(33, 0); push_word(COMMA); push_fill(40, 0);
        drain();
        check(hits == 1, "R3 one detection", hits, 1);
        check(hit_word == COMMA, "R3 pattern in lsb", hit_word, COMMA);
        check(synced == 1, "R8 set after lock", synced, 1);

        // several matching offsets: lowest chosen
        cur_tag = "R11";
        align_pat = 10'b0101010101;
        hits = 0;
        push_fill(1, 0);
        for (int i = 0; i < 60; i++) bq.push_back(i[0]);
        drain();
        check(hits > 0, "R11 detections", hits, 1);
        check(hit_word == 10'b0101010101, "R11 slice", hit_word, 10'h155);

        // complemented comma, disparity matching off then on
        cur_tag = "R5";
        align_pat = COMMA;
        push_fill(20, 0); drain();
        hits = 0;
        push_fill(26, 0); push_word(~COMMA); push_fill(30, 0);
        drain();
        check(hits == 0, "R5 complement ignored", hits, 0);
        dual_disp = 1;
        hits = 0;
        push_fill(26, 0); push_word(~COMMA); push_fill(30, 0);
        drain();
        check(hits == 1, "R5 complement matched", hits, 1);
        check(hit_word == ~COMMA, "R5 complement word", hit_word, ~COMMA);
        dual_disp = 0;

        // 7-bit pattern length
        cur_tag = "R4";
        hits = 0;
        push_fill(22, 0); push_word({3'b101, COMMA[6:0]}); push_fill(30, 0);
        drain();
        check(hits == 0, "R4 full length rejects", hits, 0);
        pat_short = 1;
        hits = 0;
        push_fill(22, 0); push_word({3'b101, COMMA[6:0]}); push_fill(30, 0);
        drain();
        check(hits == 1, "R4 short length accepts", hits, 1);
        check(hit_word[6:0] == COMMA[6:0], "R4 low bits", hit_word[6:0], COMMA[6:0]);
        pat_short = 0;

        // polarity inversion
        cur_tag = "R9";
        pol_inv = 1; fill_bit = 1;
        push_fill(20, 1); drain();
        hits = 0;
        push_fill(25, 1); push_word(~COMMA); push_fill(30, 1);
        drain();
        check(hits == 1, "R9 inverted detection", hits, 1);
        check(hit_word == COMMA, "R9 inverted word", hit_word, COMMA);
        pol_inv = 0; fill_bit = 0;
        push_fill(20, 0); drain();

        // bit reversal within a word
        cur_tag = "R10";
        hits = 0;
        push_fill(20, 0); push_word(rev10(COMMA)); push_fill(30, 0);
        drain();
        check(hits == 0, "R10 reversed ignored", hits, 0);
        bit_rev = 1;
        hits = 0;
        push_fill(20, 0); push_word(rev10(COMMA)); push_fill(30, 0);
        drain();
        check(hits == 1, "R10 reversal detection", hits, 1);
        check(hit_word == COMMA, "R10 reversal word", hit_word, COMMA);
        bit_rev = 0;
        check(synced == 1, "R8 still locked", synced, 1);

        // bit-slip mode
        cur_tag = "R6";
        push_fill(4, 0);
        for (int i = 0; i < 70; i++) push_word(COMMA);
        repeat (3) at_neg();
        mode_sel = 1;
        at_neg();
        at_neg();
        check(synced == 0, "R8 cleared on mode change", synced, 0);
        hits = 0;
        begin
            logic [9:0] w0;
            w0 = aligned_word;
            for (int p = 0; p < 10; p++) begin
                slip_req = 1; at_neg();
                slip_req = 0; at_neg(); at_neg();
            end
            check(aligned_word == w0, "R6 ten slips wrap", aligned_word, w0);
        end
        check(hits > 0, "R7 hit in slip mode", hits, 1);
        check(synced == 0, "R8 stays low in slip", synced, 0);
        drain();

        // back to manual: relock
        cur_tag = "R8";
        mode_sel = 0;
        push_fill(20, 0); drain();
        hits = 0;
        push_fill(17, 0); push_word(COMMA); push_fill(30, 0);
        drain();
        check(synced == 1, "R8 relock after mode return", synced, 1);
        check(hit_word == COMMA, "R3 relock word", hit_word, COMMA);

        // random words with disparity matching
        cur_tag = "R2";
        dual_disp = 1;
        for (int i = 0; i < 300; i++) begin
            push_word(10'($urandom));
            if (i % 37 == 0) push_word(COMMA);
        end
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired got=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule